// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Registers

This block holds the host-visible control state of one bus-master disk DMA channel. Software reaches it through an 8-bit register port. It holds a command register with a run bit and a transfer-direction bit, a status register, and a descriptor-table pointer that a separate transfer engine reads. The block drives the run and direction lines to that engine. The engine reports completion and error back into the status register.

The status register tracks three things: whether the channel is moving data, whether an error occurred, and whether an interrupt is pending. The pending interrupt is also driven on an output pin. The status register also holds software-owned flags: two per-drive DMA-capable flags and two hold flags. A completion code summarises the transfer outcome for the driver.

A timeout watchdog runs while the run bit is set. Each time its period elapses it issues a verdict: keep waiting, fail the transfer, or reset the bus. It grants only one extended wait, unless the hold flags ask it to keep waiting.

Register offsets: 0 is the command register, 2 is the status register, and 4 to 7 are the pointer bytes (least significant byte at 4). Other offsets read as zero.

Top module: `bmdma_regs`

## Requirements
- R1: Command register bit 0 is the run bit and drives `eng_start`. Bit 3 is the direction bit, set for drive-to-memory, and drives `eng_to_mem`. Both read back in place, and all other command bits read 0.
- R2: Writing the run bit from 0 to 1 sets the status active bit (bit 0). Writing the run bit to 0 clears the active bit.
- R3: Writing 1 to status bit 1 (error) or bit 2 (interrupt) clears that bit. Writing 0 to either bit leaves it unchanged, and software cannot write the active bit.
- R4: Status bits 5 and 6 are read/write DMA-capable flags for drive 0 and drive 1, and they drive `drv_capable[1:0]`. Status bits 3 and 4 are read/write hold flags.
- R5: A pulse on `eng_done` while the channel is active clears the active bit and sets the interrupt bit in the same cycle. If `eng_err` is high with it, the error bit is also set. `eng_done` has no effect while the channel is not active. If a set and a write-one-to-clear land in the same cycle, the set wins.
- R6: `end_code` is 0x00 when status bits 2..0 equal 0b100. Otherwise it equals 0x10 OR the status byte.
- R7: `irq` is high exactly when status bit 2 is set.
- R8: The 32-bit pointer is written and read by byte at offsets 4..7 and drives `desc_ptr`. Pointer writes are ignored while the active bit is set.
- R9: While the run bit is set, `wd_expire` pulses once every WD_CYCLES cycles. Its count restarts when the run bit goes from 0 to 1.
- R10: At expiry, `wd_verdict` is chosen as follows (1 = wait, 2 = fail, 3 = bus reset):
  - If both hold flags are set, the verdict is wait, and the one extended wait is kept.
  - Otherwise the extended wait is used up, and the verdict is fail if the error bit is set, wait if the active or interrupt bit is set, and bus reset otherwise.
- R11: Once the extended wait is used, a later expiry without both hold flags gives fail. Setting the run bit from 0 to 1 grants a new extended wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| desc_ptr | output | PTR_W | Descriptor table pointer to the engine |
| eng_start | output | 1 | Run command to the engine |
| eng_to_mem | output | 1 | Direction: 1 = drive to memory |
| eng_done | input | 1 | Engine transfer finished (pulse) |
| eng_err | input | 1 | Engine error, qualified by eng_done |
| drv_capable | output | 2 | Per-drive DMA-capable flags |
| irq | output | 1 | Interrupt pending |
| end_code | output | 8 | Completion code: 0 = good, else 0x10 OR status |
| wd_expire | output | 1 | Watchdog period elapsed (one cycle) |
| wd_verdict | output | 2 | Verdict at expiry: 0 none, 1 wait, 2 fail, 3 reset |

## Verification
The bench builds the block with WD_CYCLES = 16 and keeps the default 32-bit pointer. The short period lets each expiry be timed to the exact cycle. It also lets two expiries in a row be observed within one scenario, so the bench covers each of these cases:
- the hold-flag wait, which keeps the extension;
- the one free extended wait;
- the fail after the extension is used;
- the error and bus-reset verdicts;
- the new extension granted when the run bit is set again.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_CMD  = 3'd0;
    localparam logic [REG_AW-1:0] OFS_STAT = 3'd2;
    localparam int                OFS_PTR0 = 4;

    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 3;

    typedef enum logic [1:0] {
        WD_NONE  = 2'd0,
        WD_WAIT  = 2'd1,
        WD_FAIL  = 2'd2,
        WD_RESET = 2'd3
    } wd_verdict_e;

    // Packed so that the byte image is {0, cap, hold, irq, err, act}
    typedef struct packed {
        logic [1:0] cap;
        logic [1:0] hold;
        logic       irq;
        logic       err;
        logic       act;
    } stat_t;

    function automatic logic [7:0] stat_byte(input stat_t s);
        return {1'b0, s};
    endfunction

    function automatic logic [7:0] end_result(input logic [7:0] sb);
        if (sb[2:0] == 3'b100)
            return 8'h00;
        return 8'h10 | sb;
    endfunction

    function automatic wd_verdict_e wd_decide(input logic [1:0] hold,
                                              input logic       err,
                                              input logic       act,
                                              input logic       irq,
                                              input logic       ext_used);
        if (hold == 2'b11)
            return WD_WAIT;
        if (ext_used || err)
            return WD_FAIL;
        if (act || irq)
            return WD_WAIT;
        return WD_RESET;
    endfunction

endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg
    import bmdma_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              act,
    output logic              run,
    output logic              to_mem,
    output logic              run_rise,
    output logic              run_fall,
    output logic [PTR_W-1:0]  ptr
);
    localparam int PTR_BYTES = PTR_W / 8;

    logic wr_cmd;
    assign wr_cmd   = wr && (addr == OFS_CMD);
    assign run_rise = wr_cmd && wdata[CMD_RUN_BIT] && !run;
    assign run_fall = wr_cmd && !wdata[CMD_RUN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            to_mem <= 1'b0;
        end else if (wr_cmd) begin
            run    <= wdata[CMD_RUN_BIT];
            to_mem <= wdata[CMD_DIR_BIT];
        end
    end

    for (genvar g = 0; g < PTR_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                ptr[g*8 +: 8] <= '0;
            else if (wr && !act && (int'(addr) == OFS_PTR0 + g))
                ptr[g*8 +: 8] <= wdata;
        end
    end

    // R8: pointer frozen while the channel is active
    p_ptr_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (act && wr && (int'(addr) >= OFS_PTR0)) |=> $stable(ptr));

    // R1: run bit follows the last command write
    p_run_follow_r1: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> (run == $past(wdata[CMD_RUN_BIT])));

endmodule

// File: rtl/bmdma_status_reg.sv
module bmdma_status_reg
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stat,
    input  logic [6:1] wdata,
    input  logic       run_rise,
    input  logic       run_fall,
    input  logic       eng_done,
    input  logic       eng_err,
    output stat_t      st
);
    logic finish;
    assign finish = eng_done && st.act;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (wr_stat) begin
                st.cap  <= wdata[6:5];
                st.hold <= wdata[4:3];
                if (wdata[1]) st.err <= 1'b0;
                if (wdata[2]) st.irq <= 1'b0;
            end
            if (run_rise) st.act <= 1'b1;
            if (run_fall) st.act <= 1'b0;
            if (finish) begin
                st.act <= 1'b0;
                st.irq <= 1'b1;
                if (eng_err) st.err <= 1'b1;
            end
        end
    end

    // R5: completion flips active to interrupt in one cycle
    p_done_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (st.act && eng_done) |=> (st.irq && !st.act));

    // R5: error only ever rises from an engine error report
    p_err_source_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st.err) |-> $past(eng_done && eng_err));

    // R3: write-one clears error unless a new error lands
    p_w1c_err_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata[1] && !(finish && eng_err)) |=> !st.err);

    // R2: start sets active
    p_start_act_r2: assert property (@(posedge clk) disable iff (rst)
        run_rise |=> st.act);

endmodule

// File: rtl/bmdma_watchdog.sv
module bmdma_watchdog
    import bmdma_pkg::*;
#(
    parameter int WD_CYCLES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        restart,
    input  logic [1:0]  hold,
    input  logic        err,
    input  logic        act,
    input  logic        irq,
    output logic        expire,
    output wd_verdict_e verdict
);
    localparam int CNT_W = $clog2(WD_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             ext_used;

    assign expire  = run && (cnt == LAST);
    assign verdict = expire ? wd_decide(hold, err, act, irq, ext_used) : WD_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ext_used <= 1'b0;
        end else begin
            if (restart || !run || expire)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
            if (restart)
                ext_used <= 1'b0;
            else if (expire && (hold != 2'b11))
                ext_used <= 1'b1;
        end
    end

    // R9: expiry is a single-cycle pulse
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    // R10: both hold flags always keep waiting
    p_hold_wait_r10: assert property (@(posedge clk) disable iff (rst)
        (expire && hold == 2'b11) |-> (verdict == WD_WAIT));

    // R11: after the extension, a non-held expiry fails
    p_second_fail_r11: assert property (@(posedge clk) disable iff (rst)
        (expire && ext_used && hold != 2'b11) |-> (verdict == WD_FAIL));

    // R9: no verdict without expiry
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !expire |-> (verdict == WD_NONE));

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int PTR_W     = 32,
    parameter int WD_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [PTR_W-1:0]  desc_ptr,
    output logic              eng_start,
    output logic              eng_to_mem,
    input  logic              eng_done,
    input  logic              eng_err,
    output logic [1:0]        drv_capable,
    output logic              irq,
    output logic [7:0]        end_code,
    output logic              wd_expire,
    output logic [1:0]        wd_verdict
);
    localparam int PTR_BYTES = PTR_W / 8;

    logic        run_rise, run_fall;
    stat_t       st;
    logic [7:0]  sb;
    wd_verdict_e verdict;

    bmdma_cmd_reg #(.PTR_W(PTR_W)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .act      (st.act),
        .run      (eng_start),
        .to_mem   (eng_to_mem),
        .run_rise (run_rise),
        .run_fall (run_fall),
        .ptr      (desc_ptr)
    );

    bmdma_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .wr_stat  (reg_wr && (reg_addr == OFS_STAT)),
        .wdata    (reg_wdata[6:1]),
        .run_rise (run_rise),
        .run_fall (run_fall),
        .eng_done (eng_done),
        .eng_err  (eng_err),
        .st       (st)
    );

    bmdma_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
        .clk     (clk),
        .rst     (rst),
        .run     (eng_start),
        .restart (run_rise),
        .hold    (st.hold),
        .err     (st.err),
        .act     (st.act),
        .irq     (st.irq),
        .expire  (wd_expire),
        .verdict (verdict)
    );

    assign sb          = stat_byte(st);
    assign end_code    = end_result(sb);
    assign irq         = st.irq;
    assign drv_capable = st.cap;
    assign wd_verdict  = verdict;

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == OFS_CMD) begin
            reg_rdata[CMD_RUN_BIT] = eng_start;
            reg_rdata[CMD_DIR_BIT] = eng_to_mem;
        end else if (reg_addr == OFS_STAT) begin
            reg_rdata = sb;
        end else begin
            for (int i = 0; i < PTR_BYTES; i++)
                if (int'(reg_addr) == OFS_PTR0 + i)
                    reg_rdata = desc_ptr[i*8 +: 8];
        end
    end

    // R6: good completion code only for the interrupt-only pattern
    always_comb begin
        if (!rst)
            p_end_code_r6: assert ((reg_addr != OFS_STAT) ||
                                   ((reg_rdata[2:0] == 3'b100) == (end_code == 8'h00)));
    end

    // R7: interrupt pin agrees with status readback
    p_irq_pin_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_STAT) |-> (reg_rdata[2] == irq));

    // R1: engine never starts without the run command readback
    p_start_rb_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_CMD) |-> (reg_rdata[0] == eng_start));

endmodule

// File: tb/bmdma_regs_test.sv
module bmdma_regs_test;
    localparam int WD = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  reg_addr;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [31:0] desc_ptr;
    logic        eng_start, eng_to_mem, eng_done, eng_err;
    logic [1:0]  drv_capable;
    logic        irq;
    logic [7:0]  end_code;
    logic        wd_expire;
    logic [1:0]  wd_verdict;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bmdma_regs #(.PTR_W(32), .WD_CYCLES(WD)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_ptr(desc_ptr),
        .eng_start(eng_start), .eng_to_mem(eng_to_mem), .eng_done(eng_done),
        .eng_err(eng_err), .drv_capable(drv_capable), .irq(irq),
        .end_code(end_code), .wd_expire(wd_expire), .wd_verdict(wd_verdict)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic done_pulse(input logic e);
        @(negedge clk);
        eng_done = 1'b1; eng_err = e;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0;
    endtask

    task automatic wait_expire(output int n);
        n = 1;
        while (!wd_expire && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic clean();
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h06);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd0, d); chk("R1", "cmd after reset", d, 8'h00);
        rd(3'd2, d); chk("R3", "status after reset", d, 8'h00);
        chk("R7", "irq after reset", irq, 1'b0);
        chk("R6", "end code after reset", end_code, 8'h10);
    endtask

    task automatic t_command();
        logic [7:0] d;
        wr(3'd0, 8'hFF);
        rd(3'd0, d); chk("R1", "cmd readback", d, 8'h09);
        chk("R1", "eng_start", eng_start, 1'b1);
        chk("R1", "eng_to_mem", eng_to_mem, 1'b1);
        rd(3'd2, d); chk("R2", "active after start", d[0], 1'b1);
        wr(3'd0, 8'h00);
        rd(3'd2, d); chk("R2", "active after stop", d[0], 1'b0);
        chk("R1", "eng_to_mem cleared", eng_to_mem, 1'b0);
    endtask

    task automatic t_flags();
        logic [7:0] d;
        wr(3'd2, 8'h79);
        rd(3'd2, d); chk("R4", "flags readback, act not writable", d, 8'h78);
        chk("R4", "drv_capable", drv_capable, 2'b11);
        wr(3'd2, 8'h20);
        chk("R4", "drv_capable drive0 only", drv_capable, 2'b01);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_done_good();
        logic [7:0] d;
        clean();
        wr(3'd0, 8'h01);
        done_pulse(1'b0);
        rd(3'd2, d); chk("R5", "good done status", d, 8'h04);
        chk("R7", "irq pin set", irq, 1'b1);
        chk("R6", "good end code", end_code, 8'h00);
        wr(3'd2, 8'h00);
        rd(3'd2, d); chk("R3", "write 0 keeps irq", d, 8'h04);
        wr(3'd2, 8'h04);
        rd(3'd2, d); chk("R3", "w1c irq", d, 8'h00);
        chk("R7", "irq pin cleared", irq, 1'b0);
    endtask

    task automatic t_done_err();
        logic [7:0] d;
        clean();
        wr(3'd2, 8'h40);
        wr(3'd0, 8'h01);
        done_pulse(1'b1);
        rd(3'd2, d); chk("R5", "err done status", d, 8'h46);
        chk("R6", "error end code", end_code, 8'h56);
        wr(3'd2, 8'h42);
        rd(3'd2, d); chk("R3", "w1c err only", d, 8'h44);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h06);
        done_pulse(1'b1);
        rd(3'd2, d); chk("R5", "done ignored when idle", d, 8'h00);
    endtask

    task automatic t_active_end_code();
        clean();
        wr(3'd0, 8'h01);
        chk("R6", "active end code", end_code, 8'h11);
    endtask

    task automatic t_pointer();
        logic [7:0] d;
        clean();
        wr(3'd4, 8'h78); wr(3'd5, 8'h56); wr(3'd6, 8'h34); wr(3'd7, 8'h12);
        chk("R8", "desc_ptr", desc_ptr, 32'h12345678);
        rd(3'd6, d); chk("R8", "ptr byte 2 readback", d, 8'h34);
        wr(3'd0, 8'h01);
        wr(3'd4, 8'hAA);
        chk("R8", "ptr write ignored while active", desc_ptr, 32'h12345678);
        rd(3'd4, d); chk("R8", "ptr byte 0 unchanged", d, 8'h78);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_wd_extension();
        int n;
        clean();
        wr(3'd0, 8'h01);
        wait_expire(n);
        chk("R9", "first expiry cycle", n, WD);
        chk("R10", "active gives wait", wd_verdict, 2'd1);
        @(negedge clk);
        wait_expire(n);
        chk("R9", "second expiry spacing", n, WD);
        chk("R11", "after extension fails", wd_verdict, 2'd2);
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h01);
        wait_expire(n);
        chk("R11", "restart regrants extension", wd_verdict, 2'd1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_wd_hold();
        int n;
        clean();
        wr(3'd2, 8'h18);
        wr(3'd0, 8'h01);
        wait_expire(n);
        chk("R10", "hold gives wait", wd_verdict, 2'd1);
        @(negedge clk);
        wait_expire(n);
        chk("R10", "hold wait repeats", wd_verdict, 2'd1);
        wr(3'd2, 8'h00);
        @(negedge clk);
        wait_expire(n);
        chk("R10", "extension kept after hold", wd_verdict, 2'd1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_wd_error_reset();
        int n;
        clean();
        wr(3'd0, 8'h01);
        done_pulse(1'b1);
        wait_expire(n);
        chk("R10", "error gives fail", wd_verdict, 2'd2);
        wr(3'd0, 8'h00);
        clean();
        wr(3'd0, 8'h01);
        done_pulse(1'b0);
        wr(3'd2, 8'h06);
        wait_expire(n);
        chk("R10", "nothing pending gives reset", wd_verdict, 2'd3);
        wr(3'd0, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        eng_done = 1'b0; eng_err = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_command();
        t_flags();
        t_done_good();
        t_done_err();
        t_active_end_code();
        t_pointer();
        t_wd_extension();
        t_wd_hold();
        t_wd_error_reset();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule